// File: doc/BRIEF.md
# Self-clocked ADC serial frame engine

This block is the digital serial port of a delta-sigma converter whose serial clock is driven by the converter rather than by the host. The host controls one active-low chip select. While a conversion runs, an internal stand-in timer counts it out. When the conversion finishes, the result from a parallel input is packed into a 32-bit output word and held. With chip select low and a finished result waiting, the block starts a short test interval. It then produces a 32-pulse serial clock of its own. It shifts the word out on SDO and, in the same frame, takes a channel-select command from SDI.

The first bits of the command carry an enable and a five-bit channel address. That address is stored and tagged onto the result of the next conversion. The host may release chip select at any point in a frame to cut it short. A release restarts conversion at once. It keeps the old address unless the last address bit was already taken in. Chip select and SDI both pass through two-flop synchronisers before any logic uses them.

Top module: `adc_frame_engine`

## Requirements
- R1: After reset a conversion is running, sckOut is high and sdoOe is 0. The stored address and the address tagged on the first result are both 0.
- R2: sdoOe is 1 only while chip select (csN) is low, after synchronisation. Outside a frame, with csN low, sdo reads 1 while a conversion runs and 0 once the result is ready.
- R3: When csN is low and a result is ready, sckOut drops and the test interval begins. The first rising edge of sckOut follows exactly TEST_CYC clock cycles later.
- R4: A frame has exactly 32 rising edges of sckOut. Each high and each low level lasts HALF_CYC clock cycles, so rising edges are 2*HALF_CYC cycles apart.
- R5: The output word, bit 31 first, holds these fields. Bit 31 is 0 (the ready flag). Bit 30 is 0. Bit 29 is the inverted MSB of resultIn. Next come the RES_W result bits, MSB first, then the 5-bit address. After them is one parity bit, the XOR of the result and address bits. The rest are zeros. sdo changes only on falling edges of sckOut.
- R6: SDI is sampled on every rising edge of sckOut, the first included. Rising edges 1 to 8 carry 1, 0, enable, then five address bits, MSB first. Bits after the eighth are ignored. At the eighth rising edge, if enable is 1, the five address bits become the stored address. The stored address is tagged on the result of each conversion that starts later.
- R7: If csN rises during a frame, the frame ends and a new conversion starts at once, with sckOut high. An address whose eighth bit was not yet sampled is thrown away, and the stored address stays as it was.
- R8: If csN rises during the test interval, before the first rising edge, the block goes back to waiting. sckOut returns high and the held word is kept unchanged for the next frame, even if resultIn changes.
- R9: After the 32nd rising edge and one more high level, sckOut stays high, sdo reads 1 and a new conversion of CONV_CYC cycles begins. resultIn is captured when that conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select from the host, asynchronous |
| sdi | input | 1 | Serial command input, asynchronous |
| resultIn | input | RES_W | Conversion result, captured when a conversion ends |
| sckOut | output | 1 | Serial clock generated by the block |
| sdo | output | 1 | Serial data output |
| sdoOe | output | 1 | Output enable for sdo; 0 means high impedance |

## Verification
The embedded properties watch these rules on every cycle. An abort always returns the control to conversion with the clock high. Two cycles of chip select high never leave a test or a frame active. Each input sample coincides with a rising clock edge. The address store and the output shift register change only on their own strobes. Other behaviours need scenarios in the bench and cannot be seen in one cycle. These are the full word layout with its sign and parity bits, and the exact test delay and half-period widths. They also include address commit versus discard, seen through the address field of the next frame, and the held word surviving a test-interval release.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;

  localparam int FRAME_BITS = 32;
  localparam int ADDR_W     = 5;
  localparam int A0_EDGE    = 8;

  typedef enum logic [1:0] {
    ST_CONV,
    ST_SLEEP,
    ST_TEST,
    ST_DATA
  } fsmState_t;

  typedef struct packed {
    logic loadWord;
    logic startConv;
    logic sampleIn;
    logic shiftOut;
    logic commitAddr;
  } dpStrobe_t;

endpackage

// File: rtl/adcfe_sync.sv
module adcfe_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end

endmodule

// File: rtl/adcfe_ctrl.sv
module adcfe_ctrl
  import adcfe_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int TEST_CYC = 10,
  parameter int CONV_CYC = 200
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csSync,
  output logic      sckOut,
  output logic      eocN,
  output logic      inFrame,
  output dpStrobe_t stb
);

  localparam int HW = $clog2(HALF_CYC + 1);
  localparam int TW = $clog2(TEST_CYC + 1);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);

  fsmState_t      state, nState;
  logic           sck, nSck;
  logic [HW-1:0]  halfCnt, nHalf;
  logic [TW-1:0]  testCnt, nTest;
  logic [CW-1:0]  convCnt, nConv;
  logic [BW-1:0]  bitCnt, nBit;

  always_comb begin
    nState = state;
    nSck   = sck;
    nHalf  = halfCnt;
    nTest  = testCnt;
    nConv  = convCnt;
    nBit   = bitCnt;
    stb    = '0;
    case (state)
      ST_CONV: begin
        if (convCnt == CW'(CONV_CYC - 1)) begin
          stb.loadWord = 1'b1;
          nConv = '0;
          if (csSync) begin
            nState = ST_SLEEP;
          end else begin
            nState = ST_TEST;
            nSck   = 1'b0;
            nTest  = '0;
          end
        end else begin
          nConv = convCnt + 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!csSync) begin
          nState = ST_TEST;
          nSck   = 1'b0;
          nTest  = '0;
        end
      end
      ST_TEST: begin
        if (csSync) begin
          nState = ST_SLEEP;
          nSck   = 1'b1;
        end else if (testCnt == TW'(TEST_CYC - 1)) begin
          nState       = ST_DATA;
          nSck         = 1'b1;
          nHalf        = '0;
          nBit         = BW'(1);
          stb.sampleIn = 1'b1;
        end else begin
          nTest = testCnt + 1'b1;
        end
      end
      default: begin
        if (csSync) begin
          nState        = ST_CONV;
          nSck          = 1'b1;
          nConv         = '0;
          stb.startConv = 1'b1;
        end else if (halfCnt == HW'(HALF_CYC - 1)) begin
          nHalf = '0;
          if (sck) begin
            if (bitCnt == BW'(FRAME_BITS)) begin
              nState        = ST_CONV;
              nConv         = '0;
              stb.startConv = 1'b1;
            end else begin
              nSck         = 1'b0;
              stb.shiftOut = 1'b1;
            end
          end else begin
            nSck           = 1'b1;
            nBit           = bitCnt + 1'b1;
            stb.sampleIn   = 1'b1;
            stb.commitAddr = (bitCnt + 1'b1) == BW'(A0_EDGE);
          end
        end else begin
          nHalf = halfCnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CONV;
      sck     <= 1'b1;
      halfCnt <= '0;
      testCnt <= '0;
      convCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= nState;
      sck     <= nSck;
      halfCnt <= nHalf;
      testCnt <= nTest;
      convCnt <= nConv;
      bitCnt  <= nBit;
    end
  end

  assign sckOut  = sck;
  assign eocN    = (state == ST_CONV);
  assign inFrame = (state == ST_DATA);

  AST_ABORT_TO_CONV: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && csSync) |=> (state == ST_CONV && sck)); // R7

  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitCnt >= BW'(1) && bitCnt <= BW'(FRAME_BITS))); // R4

  AST_CS_HIGH_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $past(csSync) |-> (state != ST_TEST && state != ST_DATA)); // R8

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleIn |=> $rose(sck)); // R6

endmodule

// File: rtl/adcfe_dp.sv
module adcfe_dp
  import adcfe_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             sdiSync,
  input  logic [RES_W-1:0] resultIn,
  input  logic             inFrame,
  input  logic             eocN,
  output logic             sdoBit
);

  localparam int ZW = FRAME_BITS - 4 - ADDR_W - RES_W;

  logic [ADDR_W-1:0]     storedAddr;
  logic [ADDR_W-1:0]     convAddr;
  logic [4:0]            inShift;
  logic [FRAME_BITS-1:0] outShift;
  logic [FRAME_BITS-1:0] packedWord;
  logic                  parityBit;

  assign parityBit  = ^{resultIn, convAddr};
  assign packedWord = {1'b0, 1'b0, ~resultIn[RES_W-1], resultIn, convAddr,
                       parityBit, {ZW{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedAddr <= '0;
      convAddr   <= '0;
      inShift    <= '0;
      outShift   <= '0;
    end else begin
      if (stb.sampleIn) begin
        inShift <= {inShift[3:0], sdiSync};
      end
      if (stb.commitAddr && inShift[4]) begin
        storedAddr <= {inShift[3:0], sdiSync};
      end
      if (stb.startConv) begin
        convAddr <= storedAddr;
      end
      if (stb.loadWord) begin
        outShift <= packedWord;
      end else if (stb.shiftOut) begin
        outShift <= {outShift[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign sdoBit = inFrame ? outShift[FRAME_BITS-1] : eocN;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commitAddr |=> $stable(storedAddr)); // R7

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadWord || stb.shiftOut) |=> $stable(outShift)); // R8

  AST_FIELD_FIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadWord |=> outShift[FRAME_BITS-1] == 1'b0); // R5

endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
  import adcfe_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int HALF_CYC = 4,
  parameter int TEST_CYC = 10,
  parameter int CONV_CYC = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sdi,
  input  logic [RES_W-1:0] resultIn,
  output logic             sckOut,
  output logic             sdo,
  output logic             sdoOe
);

  logic [1:0] syncBus;
  logic       csSync;
  logic       sdiSync;
  logic       eocN;
  logic       inFrame;
  dpStrobe_t  stb;

  adcfe_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({csN, sdi}),
    .syncOut (syncBus)
  );

  assign csSync  = syncBus[1];
  assign sdiSync = syncBus[0];

  adcfe_ctrl #(
    .HALF_CYC (HALF_CYC),
    .TEST_CYC (TEST_CYC),
    .CONV_CYC (CONV_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csSync  (csSync),
    .sckOut  (sckOut),
    .eocN    (eocN),
    .inFrame (inFrame),
    .stb     (stb)
  );

  adcfe_dp #(.RES_W(RES_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sdiSync  (sdiSync),
    .resultIn (resultIn),
    .inFrame  (inFrame),
    .eocN     (eocN),
    .sdoBit   (sdo)
  );

  assign sdoOe = ~csSync;

  AST_OE_OFF_IN_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    (!sdoOe && !inFrame) |=> !inFrame); // R2

endmodule

// File: tb/sim_adc_frame_engine.sv
module sim_adc_frame_engine;

  localparam int HALF = 4;
  localparam int TEST = 10;
  localparam int CONV = 200;
  localparam int RW   = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          csN;
  logic          sdi;
  logic [RW-1:0] resultIn;
  logic          sckOut;
  logic          sdo;
  logic          sdoOe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_frame_engine #(
    .RES_W(RW), .HALF_CYC(HALF), .TEST_CYC(TEST), .CONV_CYC(CONV)
  ) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sdi(sdi), .resultIn(resultIn),
    .sckOut(sckOut), .sdo(sdo), .sdoOe(sdoOe)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic [RW-1:0] res,
                                         input logic [4:0] addr);
    return {1'b0, 1'b0, ~res[RW-1], res, addr, ^{res, addr}, 7'b0};
  endfunction

  // monitor: rebuilds each complete frame from sdo and compares it
  int          nRise = 0;
  int          lastRise = 0;
  logic [31:0] got = '0;
  always @(posedge sckOut or posedge csN) begin
    if (csN) begin
      nRise = 0;
    end else begin
      #1;
      got = {got[30:0], sdo};
      if (nRise > 0)
        check(cyc - lastRise == 2 * HALF, "R4 rising edge spacing",
              32'(cyc - lastRise), 32'(2 * HALF));
      lastRise = cyc;
      nRise++;
      if (nRise == 32) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 frame with no expected word", got, '0);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(got == e, t, got, e);
        end
        nRise = 0;
      end
    end
  end

  // driver: runs one frame, full or aborted after abortAt rising edges
  task automatic runFrame(input logic [4:0] addr, input bit en,
                          input int abortAt, input logic [31:0] expW,
                          input string tag);
    logic [7:0] cmd;
    int tFall;
    int rises;
    cmd = {2'b10, en, addr};
    if (abortAt == 0) begin
      expQ.push_back(expW);
      tagQ.push_back(tag);
    end
    @(negedge clk);
    csN = 1'b0;
    @(negedge sckOut);
    tFall = cyc;
    sdi = cmd[7];
    rises = 0;
    while (1) begin
      @(posedge sckOut);
      rises++;
      if (rises == 1)
        check(cyc - tFall == TEST, "R3 test delay", 32'(cyc - tFall), 32'(TEST));
      if (abortAt != 0 && rises == abortAt) begin
        #2 csN = 1'b1;
        break;
      end
      if (rises == 32) break;
      @(negedge sckOut);
      sdi = (rises < 8) ? cmd[7 - rises] : 1'b0;
    end
    if (abortAt != 0) begin
      repeat (6) @(negedge clk);
      check(sckOut == 1'b1, "R7 clock high after abort", 32'(sckOut), 32'd1);
      check(sdoOe == 1'b0, "R2 output off after release", 32'(sdoOe), 32'd0);
      csN = 1'b0;
      repeat (5) @(negedge clk);
      check(sdo == 1'b1 && sdoOe == 1'b1, "R7 conversion restarted",
            32'({sdoOe, sdo}), 32'b11);
      csN = 1'b1;
      repeat (4) @(negedge clk);
    end else begin
      repeat (HALF + 2) @(negedge clk);
      check(sckOut == 1'b1 && sdo == 1'b1, "R9 idle after frame end",
            32'({sckOut, sdo}), 32'b11);
      repeat (2 * HALF + 4) @(negedge clk);
      check(sckOut == 1'b1, "R4 no 33rd edge", 32'(sckOut), 32'd1);
      csN = 1'b1;
      repeat (3) @(negedge clk);
      check(sdoOe == 1'b0, "R2 output off with csN high", 32'(sdoOe), 32'd0);
    end
  endtask

  initial begin
    rstN = 1'b0;
    csN = 1'b1;
    sdi = 1'b0;
    resultIn = 16'h1234;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sdoOe == 1'b0, "R1 output off after reset", 32'(sdoOe), 32'd0);
    check(sckOut == 1'b1, "R1 clock high after reset", 32'(sckOut), 32'd1);

    csN = 1'b0;
    repeat (4) @(negedge clk);
    check(sdoOe == 1'b1 && sdo == 1'b1, "R2 busy flag while converting",
          32'({sdoOe, sdo}), 32'b11);

    runFrame(5'b10110, 1'b1, 0, mkWord(16'h1234, 5'b00000),
             "R1 R5 first word with reset address");
    resultIn = 16'h8001;

    // release during the test interval
    repeat (CONV + 10) @(negedge clk);
    csN = 1'b0;
    @(negedge sckOut);
    repeat (3) @(negedge clk);
    check(sckOut == 1'b0, "R3 clock low during test", 32'(sckOut), 32'd0);
    check(sdo == 1'b0, "R2 ready flag during test", 32'(sdo), 32'd0);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    check(sckOut == 1'b1 && sdoOe == 1'b0, "R8 back to waiting",
          32'({sckOut, sdoOe}), 32'b10);
    resultIn = 16'hFFFF;

    runFrame(5'b00011, 1'b0, 0, mkWord(16'h8001, 5'b10110),
             "R8 R5 held word with sign bit clear");
    resultIn = 16'h00F0;

    runFrame(5'b01001, 1'b1, 5, '0, "");
    resultIn = 16'h7F00;

    runFrame(5'b11100, 1'b0, 0, mkWord(16'h7F00, 5'b10110),
             "R7 R6 address kept after early abort and enable 0");
    resultIn = 16'hA5A5;

    runFrame(5'b01001, 1'b1, 12, '0, "");
    resultIn = 16'h0055;

    runFrame(5'b00111, 1'b1, 0, mkWord(16'h0055, 5'b01001),
             "R6 address committed at eighth edge before abort");
    resultIn = 16'h3C3C;

    runFrame(5'b10000, 1'b1, 0, mkWord(16'h3C3C, 5'b00111),
             "R6 R9 address from full frame and new result");

    check(expQ.size() == 0, "R5 all expected frames seen",
          32'(expQ.size()), 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4 frame did not complete actual=%0d expected=%0d",
               cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule